// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port attached to a simple register bus. Three configuration registers set, pin by pin, whether the pin drives (direction), whether it drives as open-drain or push-pull, and whether the pin is handed to an on-chip peripheral instead of the port data bit. The port data is reached through an address window in which the address itself carries an eight-bit pin mask. A write through the window changes only the selected pins and needs no read-modify-write. A read through it returns only the selected pins.

Every pin input passes through a two-flop synchronizer. The synchronized level can always be read, whatever the pin's direction or function. The synchronized level is also forwarded to the peripheral side for pins that are given to a peripheral. The pad side consists of an output value and an output enable per pin. Reset leaves every pin as an undriven input.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is asserted and right after it, every output enable and every output value is 0, the peripheral inputs are 0, and the direction, drive-type and function registers read back as 0.
- R2: The configuration space is selected by address bits [11:10] = 01. Within it, address bits [3:2] select the register: 0 is direction (1 = output), 1 is drive type (1 = open-drain), 2 is function select (1 = peripheral). Each register is written in full and reads back the value written.
- R3: A pin whose direction bit is 1 and whose drive-type bit is 0 has its output enable at 1 and its output value equal to its source bit. The source bit is the port data bit, or the peripheral output bit when the function-select bit is 1.
- R4: A write with address bits [11:10] = 00 takes its pin mask from address bits [9:2]. It updates the port data bit only for pins whose mask bit is 1 and leaves the other data bits unchanged.
- R5: A read with address bits [11:10] = 00 returns the synchronized pin levels ANDed with the mask from address bits [9:2]. Unselected bits read as 0. Read data appears on the read-data output in the cycle after the read request and holds until the next read.
- R6: A pin whose direction bit is 1 and whose drive-type bit is 1 never drives high. Its output value is 0, and its output enable is 1 only while its source bit is 0.
- R7: Pin inputs reach the read path through two flops. A read request taken on the same edge as the pin change, or on the following edge, still returns the old level. A read request taken on the second edge after the change returns the new level. This holds for any direction or function setting.
- R8: A pin whose function-select bit is 1 uses the peripheral output bit as its source bit, and its direction and drive-type bits still apply. Its port data bit is kept but is not driven.
- R9: The peripheral input of a pin equals its synchronized level when the pin's function-select bit is 1, and is 0 otherwise.
- R10: Accesses to configuration select 3 or to address bits [11:10] = 10 or 11 change no register and read as 0.
- R11: A pin whose direction bit is 0 has its output enable and its output value at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the access |
| busWrEn | input | 1 | Write request, one cycle per write |
| busRdEn | input | 1 | Read request, one cycle per read |
| busWrData | input | 8 | Write data, one bit per pin |
| busRdData | output | 8 | Read data, valid the cycle after busRdEn |
| pinIn | input | 8 | Asynchronous pin levels from the pads |
| padOut | output | 8 | Output value to the pads |
| padOe | output | 8 | Output enable to the pads |
| periphOut | input | 8 | Peripheral output signals, one per pin |
| periphIn | output | 8 | Synchronized pin levels forwarded to peripherals |

## Verification
The hardest case to reach from the ports is the exact synchronizer latency. Reads are taken on the same edge as a pin change and on each of the next two edges, so a missing or extra flop shows up as a wrong value on a specific read. Masking is covered by sweeping all 256 masks for writes and for sixteen pin patterns on reads. Full sweeps of the drive-type and function-select registers cover every interaction between open-drain drive and the peripheral source bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'b00,
    SPACE_CFG  = 2'b01
  } addrSpace_e;

  typedef enum logic [1:0] {
    CFG_DIR  = 2'd0,
    CFG_OD   = 2'd1,
    CFG_FUNC = 2'd2
  } cfgSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrOd;
    logic wrFunc;
    logic rdAny;
    logic rdData;
    logic rdDir;
    logic rdOd;
    logic rdFunc;
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int MASK_LSB  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output portStrobes_t         strobes,
  output logic [PIN_COUNT-1:0] accessMask
);

  localparam int SPACE_LSB = ADDR_W - 2;

  logic [1:0] spaceBits;
  logic [1:0] selBits;
  logic       isData;
  logic       isCfg;
  logic [MASK_LSB-1:0] unusedLowBits;

  assign spaceBits     = busAddr[ADDR_W-1:SPACE_LSB];
  assign selBits       = busAddr[MASK_LSB+1:MASK_LSB];
  assign accessMask    = busAddr[MASK_LSB+PIN_COUNT-1:MASK_LSB];
  assign unusedLowBits = busAddr[MASK_LSB-1:0];
  assign isData        = (spaceBits == SPACE_DATA);
  assign isCfg         = (spaceBits == SPACE_CFG);

  always_comb begin
    strobes        = '0;
    strobes.rdAny  = busRdEn;
    strobes.wrData = busWrEn && isData;
    strobes.rdData = busRdEn && isData;
    if (isCfg) begin
      unique case (selBits)
        CFG_DIR:  begin strobes.wrDir  = busWrEn; strobes.rdDir  = busRdEn; end
        CFG_OD:   begin strobes.wrOd   = busWrEn; strobes.rdOd   = busRdEn; end
        CFG_FUNC: begin strobes.wrFunc = busWrEn; strobes.rdFunc = busRdEn; end
        default:  ;
      endcase
    end
  end

  // R10: at most one register is targeted by any access
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrData, strobes.wrDir, strobes.wrOd, strobes.wrFunc}));

  // R10: the unmapped half of the address space raises no strobe
  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busAddr[ADDR_W-1] |-> !(strobes.wrData || strobes.wrDir || strobes.wrOd
                            || strobes.wrFunc || strobes.rdData));

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] accessMask,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] periphOut,
  output logic [PIN_COUNT-1:0] periphIn
);

  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] odReg;
  logic [PIN_COUNT-1:0] funcReg;
  logic [PIN_COUNT-1:0] dataReg;
  logic [PIN_COUNT-1:0] syncFirst;
  logic [PIN_COUNT-1:0] syncSecond;
  logic [PIN_COUNT-1:0] rdReg;
  logic [PIN_COUNT-1:0] rdVal;
  logic [PIN_COUNT-1:0] srcBits;
  logic [1:0]           syncAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      odReg   <= '0;
      funcReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= busWrData;
      if (strobes.wrOd)   odReg   <= busWrData;
      if (strobes.wrFunc) funcReg <= busWrData;
      if (strobes.wrData) dataReg <= (dataReg & ~accessMask) | (busWrData & accessMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncFirst  <= '0;
      syncSecond <= '0;
      syncAge    <= '0;
    end else begin
      syncFirst  <= pinIn;
      syncSecond <= syncFirst;
      if (syncAge != 2'd2) syncAge <= syncAge + 2'd1;
    end
  end

  always_comb begin
    rdVal = '0;
    if (strobes.rdData) rdVal = syncSecond & accessMask;
    if (strobes.rdDir)  rdVal = dirReg;
    if (strobes.rdOd)   rdVal = odReg;
    if (strobes.rdFunc) rdVal = funcReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdReg <= '0;
    else if (strobes.rdAny) rdReg <= rdVal;
  end

  assign busRdData = rdReg;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    assign srcBits[p]  = funcReg[p] ? periphOut[p] : dataReg[p];
    assign padOut[p]   = dirReg[p] & ~odReg[p] & srcBits[p];
    assign padOe[p]    = dirReg[p] & ~(odReg[p] & srcBits[p]);
    assign periphIn[p] = funcReg[p] & syncSecond[p];
  end

  // R1: the first cycle out of reset has no pin driven
  a_r1_reset_undriven: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0));

  // R4: a masked write leaves the unselected data bits alone
  a_r4_unmasked_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrData |=> ((dataReg & ~$past(accessMask)) == ($past(dataReg) & ~$past(accessMask))));

  // R5: unselected bits of a masked read are zero
  a_r5_unselected_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdData |=> ((busRdData & ~$past(accessMask)) == '0));

  // R6: an open-drain output never drives a one
  a_r6_od_no_high: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & odReg & padOut) == '0) && ((padOe & odReg & srcBits) == '0));

  // R7: the read path sees the pin levels two edges late
  a_r7_sync_depth: assert property (@(posedge clk) disable iff (!rstN)
    (syncAge == 2'd2) |-> (syncSecond == $past(pinIn, 2)));

  // R11: an input pin is never enabled
  a_r11_input_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & ~dirReg) == '0);

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int MASK_LSB  = 2,
  parameter int ADDR_W    = MASK_LSB + PIN_COUNT + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] periphOut,
  output logic [PIN_COUNT-1:0] periphIn
);

  portStrobes_t         strobes;
  logic [PIN_COUNT-1:0] accessMask;

  gpio_port_ctrl #(
    .PIN_COUNT(PIN_COUNT),
    .MASK_LSB (MASK_LSB),
    .ADDR_W   (ADDR_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .strobes   (strobes),
    .accessMask(accessMask)
  );

  gpio_port_datapath #(
    .PIN_COUNT(PIN_COUNT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accessMask(accessMask),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .periphOut (periphOut),
    .periphIn  (periphIn)
  );

endmodule

// File: tb/gpio_masked_port_tb_top.sv
module gpio_masked_port_tb_top;

  localparam logic [11:0] A_DIR  = 12'h400;
  localparam logic [11:0] A_OD   = 12'h404;
  localparam logic [11:0] A_FUNC = 12'h408;
  localparam logic [11:0] A_BAD  = 12'h40C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  pinIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;
  logic [7:0]  periphOut = '0;
  logic [7:0]  periphIn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_masked_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .padOut(padOut), .padOe(padOe),
    .periphOut(periphOut), .periphIn(periphIn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  function automatic logic [11:0] maskAddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] model;
    logic [7:0] src;
    repeat (3) @(negedge clk);
    // R1: reset state, during reset and right after
    check("R1 oe in reset", padOe, 8'h00);
    check("R1 out in reset", padOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", padOe, 8'h00);
    check("R1 periphIn after reset", periphIn, 8'h00);
    readReg(A_DIR, rd);  check("R1 dir reset", rd, 8'h00);
    readReg(A_OD, rd);   check("R1 od reset", rd, 8'h00);
    readReg(A_FUNC, rd); check("R1 func reset", rd, 8'h00);

    // R2: register write and read back
    writeReg(A_DIR, 8'hA5);  readReg(A_DIR, rd);  check("R2 dir", rd, 8'hA5);
    writeReg(A_OD, 8'h3C);   readReg(A_OD, rd);   check("R2 od", rd, 8'h3C);
    writeReg(A_FUNC, 8'h0F); readReg(A_FUNC, rd); check("R2 func", rd, 8'h0F);
    writeReg(A_OD, 8'h00); writeReg(A_FUNC, 8'h00);

    // R11: input pins stay undriven whatever the data bits hold
    writeReg(A_DIR, 8'h00);
    writeReg(maskAddr(8'hFF), 8'hFF);
    check("R11 oe input", padOe, 8'h00);
    check("R11 out input", padOut, 8'h00);
    writeReg(A_DIR, 8'h0F);
    check("R11 partial oe", padOe, 8'h0F);
    check("R11 partial out", padOut, 8'h0F);

    // R3/R4: all masks with push-pull outputs
    writeReg(A_DIR, 8'hFF);
    model = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] wd;
      wd = 8'((m * 37 + 11) & 255);
      writeReg(maskAddr(8'(m)), wd);
      model = (model & ~8'(m)) | (wd & 8'(m));
      check("R4 masked write", padOut, model);
      check("R3 push-pull oe", padOe, 8'hFF);
    end

    // R10: unmapped accesses
    writeReg(A_BAD, 8'hFF);
    writeReg(12'h800 | maskAddr(8'hFF), ~model);
    writeReg(12'hC00 | 12'h00C, 8'hFF);
    readReg(A_DIR, rd);  check("R10 dir kept", rd, 8'hFF);
    readReg(A_OD, rd);   check("R10 od kept", rd, 8'h00);
    readReg(A_FUNC, rd); check("R10 func kept", rd, 8'h00);
    check("R10 data kept", padOut, model);
    readReg(A_BAD, rd);  check("R10 bad reads 0", rd, 8'h00);
    readReg(12'h800, rd); check("R10 space2 reads 0", rd, 8'h00);

    // R6: every drive-type setting
    writeReg(maskAddr(8'hFF), 8'h5A);
    model = 8'h5A;
    for (int o = 0; o < 256; o++) begin
      writeReg(A_OD, 8'(o));
      check("R6 od out", padOut, model & ~8'(o));
      check("R6 od oe", padOe, ~(8'(o) & model));
    end

    // R8: every function select, open-drain on the low half
    writeReg(A_OD, 8'h0F);
    periphOut = 8'hC3;
    for (int a = 0; a < 256; a++) begin
      writeReg(A_FUNC, 8'(a));
      src = (8'(a) & periphOut) | (~8'(a) & model);
      check("R8 func out", padOut, src & 8'hF0);
      check("R8 func oe", padOe, ~(src & 8'h0F));
    end
    writeReg(A_FUNC, 8'h00);
    check("R8 data kept", padOut, model & 8'hF0);

    // R9: peripheral input gating
    pinIn = 8'h96;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      writeReg(A_FUNC, 8'(a));
      check("R9 periphIn", periphIn, 8'(a) & 8'h96);
    end

    // R7: exact synchronizer latency, with pins given to peripherals
    writeReg(A_FUNC, 8'hFF);
    writeReg(A_DIR, 8'h55);
    pinIn = 8'h69;
    readReg(maskAddr(8'hFF), rd); check("R7 same edge old", rd, 8'h96);
    readReg(maskAddr(8'hFF), rd); check("R7 next edge old", rd, 8'h96);
    readReg(maskAddr(8'hFF), rd); check("R7 second edge new", rd, 8'h69);
    busAddr = A_DIR;
    @(negedge clk);
    check("R5 read data holds", busRdData, 8'h69);

    // R5: masked reads across pin patterns and all masks
    for (int p = 0; p < 16; p++) begin
      logic [7:0] pv;
      pv = 8'((p * 91 + 29) & 255);
      pinIn = pv;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 256; m++) begin
        readReg(maskAddr(8'(m)), rd);
        check("R5 masked read", rd, pv & 8'(m));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule